// File: doc/BRIEF.md
# Interface Clock Presence Monitor

This block runs in the system clock domain and watches a second clock that is asynchronous to it and never faster than it. Every rising edge of the watched clock flips a toggle flop in that clock's own domain. The toggle passes through a two-stage synchronizer, and each change seen on the system side counts as one cycle of the watched clock. A free-running timer splits system time into windows of 128 system clocks. When a window closes with no watched edge counted in it, a sticky low-frequency flag is raised. A watched clock that has stopped, or that runs below about 1/128 of the system clock, therefore shows up within a few windows.

Software reaches the flag through a small register port: an address, a write strobe with write data, and a read data bus driven combinationally from the address. The flag sits at bit 2 of the status register at address 0. It stays set until software writes a 0 to that bit.

Top module: `clkPresenceMon`

## Requirements
- R1: After reset the flag is 0. A read of the status register (address 0) returns 8'h00, and bit 2 of that register holds the flag.
- R2: The first window starts on the first system clock after reset is released, and each window lasts 128 system clocks. With the watched clock stopped, a read after the 127th system clock edge returns 0 and a read after the 128th returns 8'h04. The flag is set again at the end of every later window that contains no watched edge.
- R3: Once set, the flag stays at 1 while the watched clock runs normally again.
- R4: A write of 8'h00 to address 0 clears the flag from the next clock edge on, provided no detection happens in the same cycle.
- R5: A write of 8'h04 to address 0, which puts a 1 in bit 2, leaves the flag unchanged.
- R6: A write to any other address has no effect on the flag. A read of any other address returns 8'h00.
- R7: When a clearing write falls in the last cycle of a window that contains no watched edge, the flag ends up set.
- R8: A watched clock at 1/64 of the system clock never sets the flag. A watched clock at 1/300 of the system clock sets it within 900 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low reset, system domain |
| monClk | input | 1 | Watched clock, asynchronous to sysClk |
| monRstN | input | 1 | Asynchronous active-low reset of the toggle flop in the watched domain |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Register address, used for both reads and writes |
| regWrData | input | DATA_W (8) | Register write data |
| regRdData | output | DATA_W (8) | Register read data, decoded combinationally from regAddr |

## Verification
Every internal fault in this block shows up only through the flag, so every fault reaches the read port. A window timer that is off by one moves the first set by one cycle, and the bench samples the read port on both sides of edge 128 to catch this. If the edge counter or synchronizer drops edges, a healthy 1/64 clock raises the flag within about three windows. If edges are invented, a 1/300 clock never sets it. A wrong clear-versus-set priority or a loose bit decode changes the read one cycle after the write.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic windowEnd;   // last system clock of the current window
    logic clearFlag;   // software asked to clear the flag
  } cpmStrobe_t;
endpackage

// File: rtl/cpm_sync.sv
module cpm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cpm_ctrl.sv
module cpm_ctrl
  import cpm_pkg::*;
#(
  parameter int WINDOW      = 128,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 0,
  parameter int FLAG_BIT    = 2
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output cpmStrobe_t        strb
);
  localparam int TMR_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [TMR_W-1:0]  LAST_TICK = TMR_W'(WINDOW - 1);
  localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

  logic [TMR_W-1:0] winTimer;
  logic             addrHit;

  // Window timer: free-running, restarts at 0 after the last tick.
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)                 winTimer <= '0;
    else if (winTimer == LAST_TICK) winTimer <= '0;
    else                          winTimer <= winTimer + 1'b1;
  end

  assign addrHit = (regAddr == ADDR_W'(STATUS_ADDR));

  always_comb begin
    strb.windowEnd = (winTimer == LAST_TICK);
    strb.clearFlag = regWrEn && addrHit && ((regWrData & FLAG_MASK) == '0);
  end

  // R2: the timer never leaves its range and restarts after each window end.
  a_r2_timer_range: assert property (@(posedge sysClk) disable iff (!sysRstN)
    winTimer <= LAST_TICK);
  a_r2_window_wrap: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strb.windowEnd |=> (winTimer == '0));
  // R5, R6: a clear is requested only by a write.
  a_r5_clear_needs_write: assert property (@(posedge sysClk) disable iff (!sysRstN)
    strb.clearFlag |-> regWrEn);
endmodule

// File: rtl/cpm_dp.sv
module cpm_dp
  import cpm_pkg::*;
#(
  parameter int WINDOW      = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 0,
  parameter int FLAG_BIT    = 2
) (
  input  logic              monClk,
  input  logic              monRstN,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  cpmStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regRdData
);
  localparam int CNT_W = $clog2(WINDOW) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             monToggle;
  logic             togSync;
  logic             togPrev;
  logic             edgePulse;
  logic [CNT_W-1:0] edgeCnt;
  logic             windowEmpty;
  logic             setReq;
  logic             lowFreqFlag;

  // Watched domain: one toggle per watched clock cycle.
  always_ff @(posedge monClk or negedge monRstN) begin
    if (!monRstN) monToggle <= 1'b0;
    else          monToggle <= ~monToggle;
  end

  cpm_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (sysClk),
    .rstN (sysRstN),
    .d    (monToggle),
    .q    (togSync)
  );

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) togPrev <= 1'b0;
    else          togPrev <= togSync;
  end

  assign edgePulse = togSync ^ togPrev;

  // Saturating count of watched edges within the current window.
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)                          edgeCnt <= '0;
    else if (strb.windowEnd)               edgeCnt <= '0;
    else if (edgePulse && edgeCnt != CNT_MAX) edgeCnt <= edgeCnt + 1'b1;
  end

  assign windowEmpty = (edgeCnt == '0) && !edgePulse;
  assign setReq      = strb.windowEnd && windowEmpty;

  // Sticky flag: detection has priority over a software clear.
  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN)            lowFreqFlag <= 1'b0;
    else if (setReq)         lowFreqFlag <= 1'b1;
    else if (strb.clearFlag) lowFreqFlag <= 1'b0;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(STATUS_ADDR)) regRdData[FLAG_BIT] = lowFreqFlag;
  end

  // R3: flag holds unless a clear is requested.
  a_r3_sticky: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (lowFreqFlag && !strb.clearFlag) |=> lowFreqFlag);
  // R2: an empty window always leaves the flag set.
  a_r2_set_on_empty: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strb.windowEnd && edgeCnt == '0 && !edgePulse) |=> lowFreqFlag);
  // R2: the flag can only rise right after a window end.
  a_r2_rise_at_end: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(lowFreqFlag) |-> $past(strb.windowEnd));
  // R4: a clear outside a detection drops the flag.
  a_r4_clear: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strb.clearFlag && !strb.windowEnd) |=> !lowFreqFlag);
  // R7: a clear that meets a detection leaves the flag set.
  a_r7_set_wins: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strb.clearFlag && setReq) |=> lowFreqFlag);
endmodule

// File: rtl/clkPresenceMon.sv
module clkPresenceMon
  import cpm_pkg::*;
#(
  parameter int WINDOW      = 128,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int STATUS_ADDR = 0,
  parameter int FLAG_BIT    = 2
) (
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              monClk,
  input  logic              monRstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  cpmStrobe_t strb;

  cpm_ctrl #(
    .WINDOW(WINDOW), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .FLAG_BIT(FLAG_BIT)
  ) uCtrl (
    .sysClk    (sysClk),
    .sysRstN   (sysRstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  cpm_dp #(
    .WINDOW(WINDOW), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .STATUS_ADDR(STATUS_ADDR), .FLAG_BIT(FLAG_BIT)
  ) uDp (
    .monClk    (monClk),
    .monRstN   (monRstN),
    .sysClk    (sysClk),
    .sysRstN   (sysRstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regRdData (regRdData)
  );
endmodule

// File: tb/sim_clkPresenceMon.sv
`timescale 1ns/1ps
module sim_clkPresenceMon;
  logic       sysClk = 1'b0;
  logic       sysRstN = 1'b0;
  logic       monClk = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = 4'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;

  int   nChecks = 0;
  int   nFail   = 0;
  bit   monRun  = 1'b0;
  int   monHalf = 100;
  bit   sampleReq = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  clkPresenceMon u0 (
    .sysClk(sysClk), .sysRstN(sysRstN), .monClk(monClk), .monRstN(sysRstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData)
  );

  always #10 sysClk = ~sysClk;   // 50 MHz

  always begin
    if (monRun) #(monHalf) monClk = ~monClk;
    else begin monClk = 1'b0; #20; end
  end

  // Monitor: pops the expected value and compares at the negative edge.
  always @(negedge sysClk) begin
    if (sampleReq) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChecks++;
      if (regRdData !== e) begin
        nFail++;
        $display("FAIL %s: regRdData=%h expected %h", t, regRdData, e);
      end
    end
  end

  // Driver tasks: called about 2 ns after a positive edge.
  task automatic readExp(input logic [3:0] addr, input logic [7:0] e, input string t);
    regAddr = addr;
    expQ.push_back(e);
    tagQ.push_back(t);
    sampleReq = 1'b1;
    @(negedge sysClk);
    #1 sampleReq = 1'b0;
    regAddr = 4'd0;
  endtask

  task automatic nextEdge();
    @(posedge sysClk);
    #2;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge sysClk);
    #2;
  endtask

  task automatic writeReg(input logic [3:0] addr, input logic [7:0] d);
    regAddr = addr; regWrData = d; regWrEn = 1'b1;
    nextEdge();
    regWrEn = 1'b0; regAddr = 4'd0; regWrData = 8'd0;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: state during reset
    repeat (3) @(posedge sysClk);
    #2 readExp(4'd0, 8'h00, "R1 reset");
    @(negedge sysClk) sysRstN = 1'b1;   // release between edges
    // R2: watched clock stopped; window ends at edge 128
    waitEdges(127);
    readExp(4'd0, 8'h00, "R2 before first window end");
    nextEdge();                           // edge 128
    readExp(4'd0, 8'h04, "R2 first window end");
    // R7: clear during the last cycle of window 2 (edge 256)
    waitEdges(127);                       // edge 255
    writeReg(4'd0, 8'h00);                // takes effect at edge 256
    readExp(4'd0, 8'h04, "R7 detection beats clear");
    // R4: clear away from a window end (edge 257)
    writeReg(4'd0, 8'h00);
    readExp(4'd0, 8'h00, "R4 clear");
    // R2: re-detection at edge 384
    waitEdges(126);                       // edge 383
    readExp(4'd0, 8'h00, "R2 before third window end");
    nextEdge();                           // edge 384
    readExp(4'd0, 8'h04, "R2 third window end");
    // R5: writing 1 to bit 2 keeps the flag
    nextEdge();
    writeReg(4'd0, 8'h04);
    readExp(4'd0, 8'h04, "R5 write one ignored");
    // R6: write to another address, read of another address
    writeReg(4'd1, 8'h00);
    readExp(4'd0, 8'h04, "R6 other address write ignored");
    nextEdge();
    readExp(4'd1, 8'h00, "R6 other address reads zero");
    // R3: flag stays set with a fast watched clock
    monHalf = 100; monRun = 1'b1;         // 1/10 of system clock
    waitEdges(600);
    readExp(4'd0, 8'h04, "R3 sticky while clock runs");
    writeReg(4'd0, 8'h00);
    readExp(4'd0, 8'h00, "R4 clear with clock running");
    waitEdges(1000);
    readExp(4'd0, 8'h00, "R8 fast clock no detection");
    // R8: 1/64 of system clock
    monHalf = 640;
    waitEdges(300);
    writeReg(4'd0, 8'h00);
    waitEdges(1000);
    readExp(4'd0, 8'h00, "R8 one-64th clock no detection");
    // R8: 1/300 of system clock
    monHalf = 3000;
    waitEdges(300);
    writeReg(4'd0, 8'h00);
    readExp(4'd0, 8'h00, "R4 clear before slow run");
    waitEdges(900);
    readExp(4'd0, 8'h04, "R8 slow clock detected");
    nextEdge();
    if (expQ.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard: %0d items left, expected 0", expQ.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule